// File: doc/BRIEF.md
# Register Write Command Executor

This block is a small fetch-and-execute engine. It reads a list of register-programming instructions from a memory read port and turns each one into a write transaction on a register write port. Software first sets the enable bit in a control register. It then loads a head byte address and a tail byte address. Loading the tail launches the engine. The engine walks word by word from head to tail and keeps `busy` high until the fetch pointer reaches the tail.

Each instruction is a pair of 32-bit words that starts on an 8-byte boundary. The lower word carries the data or a count. The upper word carries the opcode in bits 31:24, a byte-enable field in bits 23:20 and a 20-bit register offset in bits 19:0. The engine can do two kinds of write. A direct write sends one value. An indexed burst sends a counted run of data words to a single offset. Two wait instructions stall execution until a number of external pulses has been seen: microsecond ticks for one, line-start pulses for the other. Software pads the end of a list with zero words up to a 64-byte line, and those zero words run as no-ops. The engine never issues a read to the register space.

Top module: `reg_cmd_engine`

## Requirements
- R1: After reset, `busy`, `err`, `mem_req` and `wr_valid` are all low.
- R2: A tail write (`cfg_sel`=2) with enable set (`cfg_sel`=0, bit 0 = 1) starts fetching at the head address (`cfg_sel`=1). A tail write while enable is clear starts nothing and produces no write.
- R3: The instruction at byte address A is read as its lower word from A and its upper word from A+4. Opcode is upper[31:24], byte enables are upper[23:20] and offset is upper[19:0]. Every memory address is word aligned.
- R4: Opcode 0x01 issues exactly one write. That write has `wr_addr` = offset, `wr_data` = lower word and `wr_strb` = upper[23:20].
- R5: Opcode 0x09 takes the lower word as a count N. It issues N writes to the same offset, in order, using the N words that follow, all with `wr_strb`=4'hF. When N is odd, the single pad word after the data is skipped and never executed. N=0 issues nothing.
- R6: Opcode 0x00 and the stub opcodes 0x04, 0x05, 0x06, 0x07 and 0x0A each consume 8 bytes. They issue no write and leave `err` low. A list made of zero words runs to the tail with no write.
- R7: Opcode 0x02 holds execution until the lower word's count of `tick_us` pulses has been seen after the wait begins. The next write is not issued with one pulse fewer than that count.
- R8: Opcode 0x03 does the same with `line_start` pulses. `tick_us` pulses do not advance it.
- R9: Any other opcode is skipped as 8 bytes and sets `err`. `err` stays set until the next start, which clears it.
- R10: `busy` is high from the cycle after a starting tail write until the fetch pointer equals the tail. While `busy` is low, `mem_req` and `wr_valid` are low.
- R11: A control write that clears enable makes `busy`, `mem_req` and `wr_valid` low on the next cycle. No further write is issued and later pulses have no effect.
- R12: A pending write holds `wr_valid`, `wr_addr`, `wr_data` and `wr_strb` stable until `wr_ready`. A pending fetch holds `mem_req` and `mem_addr` until `mem_ack`. The engine never requests memory and drives a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_sel | input | 2 | 0 control (bit 0 enable), 1 head, 2 tail |
| cfg_wdata | input | AW | Control write data |
| busy | output | 1 | Engine is running |
| err | output | 1 | Sticky unknown-opcode flag |
| mem_req | output | 1 | Instruction memory read request |
| mem_addr | output | AW | Byte address of the requested word |
| mem_ack | input | 1 | Read data valid; completes the request |
| mem_rdata | input | 32 | Read data |
| wr_valid | output | 1 | Register write pending |
| wr_addr | output | 20 | Register offset |
| wr_data | output | 32 | Write data |
| wr_strb | output | 4 | Per-byte write enables |
| wr_ready | input | 1 | Write accepted |
| tick_us | input | 1 | One-cycle microsecond tick |
| line_start | input | 1 | One-cycle line-start pulse |

## Verification
Several rules are checked by assertions on every cycle. These are the handshake rules (stable write and stable fetch while stalled), the exclusion between fetching and writing, word-aligned addresses, an idle engine staying quiet, a one-cycle abort and the stickiness of `err`. Other behaviour can only be shown by the bench's scenarios: decode of each opcode, the order and strobes of burst data, skipping of the odd pad word, exact pulse counts in the two waits, and clearing `err` on restart. The bench shows these by running directed and randomly built instruction lists against an expected write stream under random back-pressure.

// File: rtl/reg_cmd_engine.sv
module reg_cmd_engine #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  output logic          busy,
  output logic          err,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic          wr_valid,
  output logic [19:0]   wr_addr,
  output logic [31:0]   wr_data,
  output logic [3:0]    wr_strb,
  input  logic          wr_ready,
  input  logic          tick_us,
  input  logic          line_start
);

  localparam logic [AW-1:0] WSTEP = AW'(4);
  localparam logic [7:0] OP_NOP  = 8'h00;
  localparam logic [7:0] OP_WR   = 8'h01;
  localparam logic [7:0] OP_WUS  = 8'h02;
  localparam logic [7:0] OP_WLN  = 8'h03;
  localparam logic [7:0] OP_WVB  = 8'h04;
  localparam logic [7:0] OP_WIN  = 8'h05;
  localparam logic [7:0] OP_WOUT = 8'h06;
  localparam logic [7:0] OP_IRQ  = 8'h07;
  localparam logic [7:0] OP_IDX  = 8'h09;
  localparam logic [7:0] OP_POLL = 8'h0A;

  typedef enum logic [2:0] {
    S_IDLE, S_LO, S_HI, S_DEC, S_WR, S_WAIT, S_IRD, S_IWR
  } st_t;

  st_t           state;
  logic          en;
  logic [AW-1:0] head, tail, ptr;
  logic [31:0]   lo, hi, cnt;
  logic          wait_line;

  wire abort = cfg_we && (cfg_sel == 2'd0) && !cfg_wdata[0];
  wire start = cfg_we && (cfg_sel == 2'd2) && en;
  wire pulse = wait_line ? line_start : tick_us;

  assign busy     = (state != S_IDLE);
  assign mem_req  = ((state == S_LO) && (ptr != tail)) || (state == S_HI) || (state == S_IRD);
  assign mem_addr = ptr;
  assign wr_valid = (state == S_WR) || (state == S_IWR);
  assign wr_addr  = hi[19:0];
  assign wr_data  = lo;
  assign wr_strb  = (state == S_IWR) ? 4'hF : hi[23:20];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en   <= 1'b0;
      head <= '0;
      tail <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        2'd0:    en   <= cfg_wdata[0];
        2'd1:    head <= cfg_wdata;
        2'd2:    tail <= cfg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      ptr       <= '0;
      lo        <= '0;
      hi        <= '0;
      cnt       <= '0;
      wait_line <= 1'b0;
      err       <= 1'b0;
    end else if (abort) begin
      state <= S_IDLE;
    end else if (start) begin
      state <= S_LO;
      ptr   <= head;
      err   <= 1'b0;
    end else begin
      case (state)
        S_LO: begin
          if (ptr == tail) state <= S_IDLE;
          else if (mem_ack) begin
            lo    <= mem_rdata;
            ptr   <= ptr + WSTEP;
            state <= S_HI;
          end
        end
        S_HI: begin
          if (mem_ack) begin
            hi    <= mem_rdata;
            ptr   <= ptr + WSTEP;
            state <= S_DEC;
          end
        end
        S_DEC: begin
          case (hi[31:24])
            OP_WR: state <= S_WR;
            OP_WUS, OP_WLN: begin
              cnt       <= lo;
              wait_line <= (hi[31:24] == OP_WLN);
              state     <= S_WAIT;
            end
            OP_IDX: begin
              cnt   <= lo;
              state <= (lo == 32'd0) ? S_LO : S_IRD;
            end
            OP_NOP, OP_WVB, OP_WIN, OP_WOUT, OP_IRQ, OP_POLL: state <= S_LO;
            default: begin
              err   <= 1'b1;
              state <= S_LO;
            end
          endcase
        end
        S_WR: if (wr_ready) state <= S_LO;
        S_WAIT: begin
          if (cnt == 32'd0) state <= S_LO;
          else if (pulse) cnt <= cnt - 32'd1;
        end
        S_IRD: begin
          if (mem_ack) begin
            lo    <= mem_rdata;
            ptr   <= ptr + WSTEP;
            cnt   <= cnt - 32'd1;
            state <= S_IWR;
          end
        end
        S_IWR: begin
          if (wr_ready) begin
            if (cnt != 32'd0) state <= S_IRD;
            else begin
              if (ptr[2]) ptr <= ptr + WSTEP;
              state <= S_LO;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/reg_cmd_engine_chk.sv
module reg_cmd_engine_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [1:0]    cfg_sel,
  input logic [AW-1:0] cfg_wdata,
  input logic          busy,
  input logic          err,
  input logic          mem_req,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ack,
  input logic          wr_valid,
  input logic [19:0]   wr_addr,
  input logic [31:0]   wr_data,
  input logic [3:0]    wr_strb,
  input logic          wr_ready
);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !wr_valid));

  p_word_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  p_one_op_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && wr_valid));

  p_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == 2'd0 && !cfg_wdata[0]) |=> (!busy && !mem_req && !wr_valid));

  p_wr_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready && !cfg_we) |=>
      (wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(wr_strb)));

  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !cfg_we) |=> (mem_req && $stable(mem_addr)));

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !cfg_we) |=> err);

endmodule

bind reg_cmd_engine reg_cmd_engine_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
  .busy(busy), .err(err), .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
  .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb),
  .wr_ready(wr_ready)
);

// File: tb/tb_reg_cmd_engine.sv
`timescale 1ns/1ps
module tb_reg_cmd_engine;
  localparam int AW = 16;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0; logic [1:0] cfg_sel = 0; logic [AW-1:0] cfg_wdata = 0;
  logic busy, err, mem_req, mem_ack = 0, wr_valid, wr_ready = 0;
  logic [AW-1:0] mem_addr; logic [31:0] mem_rdata = 0;
  logic [19:0] wr_addr; logic [31:0] wr_data; logic [3:0] wr_strb;
  logic tick_us = 0, line_start = 0;

  reg_cmd_engine #(.AW(AW)) dut (.*);

  always #2 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  logic [31:0] mem [0:1023];
  logic [19:0] ex_a [0:255]; logic [31:0] ex_d [0:255]; logic [3:0] ex_s [0:255];
  logic [19:0] gt_a [0:255]; logic [31:0] gt_d [0:255]; logic [3:0] gt_s [0:255];
  int ex_n = 0, gt_n = 0, wp = 0, base_w = 0;
  bit exp_err = 0, rnd_hs = 1, stall_wr = 0, auto_pulse = 0;
  int tick_pend = 0, line_pend = 0;

  always @(negedge clk) begin
    bit r1, r2;
    r1 = rnd_hs ? ($urandom % 4 != 0) : 1'b1;
    if (stall_wr) r1 = 0;
    if (wr_valid && r1 && gt_n < 256) begin
      gt_a[gt_n] = wr_addr; gt_d[gt_n] = wr_data; gt_s[gt_n] = wr_strb; gt_n++;
    end
    wr_ready = r1;
    r2 = rnd_hs ? ($urandom % 3 != 0) : 1'b1;
    mem_ack = mem_req && r2;
    mem_rdata = mem_ack ? mem[mem_addr[11:2]] : 32'd0;
    if (auto_pulse) begin
      tick_us = ($urandom % 3 == 0); line_start = ($urandom % 4 == 0);
    end else begin
      tick_us = (tick_pend > 0); if (tick_pend > 0) tick_pend--;
      line_start = (line_pend > 0); if (line_pend > 0) line_pend--;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin n_bad++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic cfg(input logic [1:0] s, input logic [AW-1:0] d);
    @(negedge clk); cfg_we = 1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk); cfg_we = 0; #1;
  endtask

  function automatic logic [31:0] hiw(input logic [7:0] op, input logic [3:0] be, input logic [19:0] off);
    return {op, be, off};
  endfunction

  task automatic begin_prog(input int bw);
    base_w = bw; wp = bw; ex_n = 0; exp_err = 0;
  endtask
  task automatic emit(input logic [31:0] l, input logic [31:0] h);
    mem[wp] = l; mem[wp+1] = h; wp += 2;
  endtask
  task automatic add_exp(input logic [19:0] a, input logic [31:0] d, input logic [3:0] s);
    ex_a[ex_n] = a; ex_d[ex_n] = d; ex_s[ex_n] = s; ex_n++;
  endtask
  task automatic p_write(input logic [19:0] off, input logic [31:0] d, input logic [3:0] be);
    emit(d, hiw(8'h01, be, off)); add_exp(off, d, be);
  endtask
  task automatic p_idx(input logic [19:0] off, input int n);
    emit(n, hiw(8'h09, 4'h0, off));
    for (int k = 0; k < n; k++) begin
      logic [31:0] d; d = $urandom; mem[wp] = d; wp++; add_exp(off, d, 4'hF);
    end
    if (n % 2) begin mem[wp] = 32'h0200_0005; wp++; end
  endtask
  task automatic p_op(input logic [7:0] op, input logic [31:0] l);
    emit(l, hiw(op, 4'($urandom), 20'($urandom)));
    if (!(op inside {8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h09, 8'h0A})) exp_err = 1;
  endtask
  task automatic finish_prog();
    while (wp % 16 != 0) begin mem[wp] = 0; wp++; end
  endtask
  task automatic launch();
    gt_n = 0;
    cfg(0, 1); cfg(1, AW'(base_w * 4)); cfg(2, AW'(wp * 4));
  endtask
  task automatic wait_idle(input string req);
    int n; n = 0;
    while (busy && n < 5000) begin cyc(1); n++; end
    chk(!busy, req, busy, 0);
  endtask
  task automatic compare(input string req);
    chk(gt_n == ex_n, req, gt_n, ex_n);
    for (int i = 0; i < ex_n && i < gt_n; i++) begin
      chk(gt_a[i] == ex_a[i], req, gt_a[i], ex_a[i]);
      chk(gt_d[i] == ex_d[i], req, gt_d[i], ex_d[i]);
      chk(gt_s[i] == ex_s[i], req, gt_s[i], ex_s[i]);
    end
  endtask

  initial begin
    #600000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 1024; i++) mem[i] = 0;
    cyc(5); rst_n = 1; cyc(1);
    // R1 reset state
    chk(busy == 0, "R1 busy", busy, 0);
    chk(err == 0, "R1 err", err, 0);
    chk(mem_req == 0, "R1 mem_req", mem_req, 0);
    chk(wr_valid == 0, "R1 wr_valid", wr_valid, 0);

    // R2 tail write without enable
    begin_prog(64); p_write(20'h11, 32'hAA, 4'hF); finish_prog();
    gt_n = 0;
    cfg(0, 0); cfg(1, AW'(base_w * 4)); cfg(2, AW'(wp * 4));
    chk(busy == 0, "R2 no start when disabled", busy, 0);
    cyc(30);
    chk(gt_n == 0, "R2 no write when disabled", gt_n, 0);

    // R3 R4 R5 R6 directed mix
    begin_prog(128);
    p_write(20'h12345, 32'hDEADBEEF, 4'h5);
    p_idx(20'h00400, 1);
    p_op(8'h00, 32'h1);
    p_idx(20'h00404, 2);
    p_op(8'h04, 32'h7); p_op(8'h05, 0); p_op(8'h06, 0); p_op(8'h07, 0); p_op(8'h0A, 3);
    p_idx(20'h00408, 3);
    p_idx(20'h0040C, 0);
    p_write(20'hFFFFF, 32'h01234567, 4'h8);
    finish_prog();
    launch();
    chk(busy == 1, "R10 busy after start", busy, 1);
    wait_idle("R10 completes");
    compare("R3 R4 R5 directed stream");
    chk(err == 0, "R6 stubs leave err low", err, 0);

    // R6 zero-only line
    begin_prog(256);
    for (int i = 0; i < 16; i++) begin mem[wp] = 0; wp++; end
    launch();
    chk(busy == 1, "R10 busy on zero line", busy, 1);
    wait_idle("R6 zero line completes");
    chk(gt_n == 0, "R6 zero words issue no write", gt_n, 0);

    // R9 unknown opcode
    begin_prog(320);
    p_write(20'h21, 32'h1111, 4'h3); p_op(8'h08, 32'h5); p_write(20'h22, 32'h2222, 4'hC); p_op(8'hC3, 0);
    finish_prog(); launch(); wait_idle("R9 run");
    compare("R9 writes around unknown op");
    chk(err == 1, "R9 err set", err, 1);
    cyc(10);
    chk(err == 1, "R9 err sticky", err, 1);
    begin_prog(384); p_write(20'h30, 32'h3, 4'hF); finish_prog(); launch();
    chk(err == 0, "R9 err cleared on start", err, 0);
    wait_idle("R9 second run");

    // R7 wait microseconds
    rnd_hs = 0;
    begin_prog(448); p_write(20'h40, 32'hA, 4'hF); p_op(8'h02, 5); p_write(20'h41, 32'hB, 4'hF); finish_prog();
    launch(); cyc(60);
    chk(gt_n == 1 && busy, "R7 held before ticks", gt_n, 1);
    line_pend = 8; cyc(30);
    chk(gt_n == 1, "R7 line pulses ignored", gt_n, 1);
    tick_pend = 4; cyc(30);
    chk(gt_n == 1, "R7 held after count-1 ticks", gt_n, 1);
    tick_pend = 1; cyc(30);
    chk(gt_n == 2, "R7 released after count ticks", gt_n, 2);
    wait_idle("R7 run"); compare("R7 stream");

    // R8 wait lines
    begin_prog(512); p_write(20'h50, 32'hC, 4'hF); p_op(8'h03, 3); p_write(20'h51, 32'hD, 4'hF); finish_prog();
    launch(); cyc(60);
    tick_pend = 10; cyc(30);
    chk(gt_n == 1, "R8 ticks ignored in line wait", gt_n, 1);
    line_pend = 2; cyc(30);
    chk(gt_n == 1, "R8 held after count-1 lines", gt_n, 1);
    line_pend = 1; cyc(30);
    chk(gt_n == 2, "R8 released after count lines", gt_n, 2);
    wait_idle("R8 run");

    // R11 abort during wait
    begin_prog(576); p_write(20'h60, 32'hE, 4'hF); p_op(8'h02, 3); p_write(20'h61, 32'hF, 4'hF); finish_prog();
    launch(); cyc(60);
    cfg(0, 0);
    chk(busy == 0 && mem_req == 0 && wr_valid == 0, "R11 abort idles", {busy, mem_req, wr_valid}, 0);
    tick_pend = 6; cyc(40);
    chk(gt_n == 1, "R11 no write after abort", gt_n, 1);

    // R12 stalled write then R11 abort
    stall_wr = 1;
    begin_prog(640); p_write(20'h70, 32'h77, 4'h2); finish_prog();
    launch(); cyc(40);
    chk(wr_valid == 1 && wr_addr == 20'h70 && wr_strb == 4'h2, "R12 write held while stalled", {wr_valid, wr_addr, wr_strb}, {1'b1, 20'h70, 4'h2});
    cfg(0, 0);
    chk(wr_valid == 0 && busy == 0, "R11 abort drops pending write", {wr_valid, busy}, 0);
    stall_wr = 0; cyc(20);
    chk(gt_n == 0, "R11 aborted write never accepted", gt_n, 0);

    // random programs
    rnd_hs = 1; auto_pulse = 1;
    for (int t = 0; t < 30; t++) begin
      int ni;
      begin_prog(($urandom % 7) * 128);
      ni = 1 + $urandom % 12;
      for (int j = 0; j < ni; j++) begin
        int k; k = $urandom % 10;
        case (k)
          0, 1, 2, 3: p_write(20'($urandom), $urandom, 4'($urandom));
          4, 5: p_idx(20'($urandom), $urandom % 7);
          6: p_op(8'h00, $urandom);
          7: begin
            int s; s = $urandom % 5;
            p_op(s == 0 ? 8'h04 : s == 1 ? 8'h05 : s == 2 ? 8'h06 : s == 3 ? 8'h07 : 8'h0A, $urandom);
          end
          8: p_op(($urandom % 2) ? 8'h02 : 8'h03, $urandom % 4);
          default: p_op(8'h0B + 8'($urandom % 200), $urandom);
        endcase
      end
      finish_prog(); launch(); wait_idle("R10 random run completes");
      compare("R4 R5 random stream");
      chk(err == exp_err, "R9 random err flag", err, exp_err);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule